// File: doc/BRIEF.md
# Power-Good Read Host Sequencer

This block sits on the host side of a power supply's three-line bidirectional control port. In normal operation it drives one enable level per output module onto the shared lines. A low level switches the matching module off. A high level switches it on. Line 1 serves module 1, line 2 serves module 2 and line 3 serves module 3.

When user logic asks for a status snapshot, the block runs the read handshake:

1. It raises the read-request output.
2. It releases its line drivers a fixed time later.
3. It waits for the supply's data-valid input.
4. It captures the line levels and masks off positions with no module fitted.
5. It drops the request.
6. It drives the lines again after a fixed delay.

If the supply never signals valid data, the read is abandoned, the lines are restored on the same schedule, and a sticky error flag is set. Enable commands that change during a read are held back and applied only when the drivers come back.

All delays are counted in clock cycles derived from a cycles-per-millisecond parameter. The release delay is 1 ms and must stay under 3 ms. The re-drive delay is 2 ms and must fall inside the 1 to 4 ms window. The valid timeout is 500 ms. The data-valid input and the line levels pass through a synchronizer before use.

Top module: `pg_read_seq`

## Requirements
- R1: While reset is high, the outputs hold these values: pg_req 0, line_oe all ones, line_out all zeros, status 0, status_vld 0, busy 0, timeout_err 0.
- R2: While idle, line_out bit i copies en_cmd bit i one cycle later. Bit 0 is line 1 and module 1. A 0 disables a module and a 1 enables it.
- R3: rd_go high in a cycle while busy is low makes pg_req rise at the next edge. rd_go while busy is ignored, so each read produces exactly one pg_req rising edge.
- R4: line_oe goes from all ones to all zeros exactly RELEASE_MS*CLK_PER_MS cycles after pg_req rises, and at no other time.
- R5: Once drivers are released, pg_valid high causes the following on one edge:
  - status is loaded with the synchronized line levels ANDed with POP_MASK, where bit i of the mask covers line i+1;
  - status_vld pulses for one cycle;
  - pg_req falls.

  status is unchanged otherwise.
- R6: line_oe returns to all ones exactly RESTORE_MS*CLK_PER_MS cycles after pg_req falls. line_out then carries the latest en_cmd.
- R7: If pg_valid is not seen within TIMEOUT_MS*CLK_PER_MS cycles of the driver release, the read ends as follows:
  - pg_req falls at that count;
  - timeout_err is set and stays set until reset;
  - no status_vld pulse occurs and status keeps its old value.
- R8: busy is high exactly from the pg_req rising edge until line_oe returns to all ones.
- R9: line_out does not change while busy is high, whatever en_cmd does.
- R10: pg_valid high while idle has no effect on status, status_vld or pg_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cmd | input | N_LINES | Requested enable level per module |
| rd_go | input | 1 | Start a power-good read |
| line_out | output | N_LINES | Level driven onto each control line |
| line_oe | output | N_LINES | Output enable of each line driver |
| line_in | input | N_LINES | Level sensed at each control line pad |
| pg_req | output | 1 | Read-request line to the supply |
| pg_valid | input | 1 | Supply's status-valid indication |
| status | output | N_LINES | Masked power-good snapshot, bit high = module good |
| status_vld | output | 1 | One-cycle pulse when status is updated |
| busy | output | 1 | Read handshake in progress |
| timeout_err | output | 1 | Sticky flag: a read timed out |

## Verification
The bench counts cycles from each request edge to the matching driver change. An off-by-one phase timer would move the release or the re-drive by one cycle and be reported. Reads use a mask with an empty third position and supply patterns that light different lines. A design that forgot the mask, or mapped lines to the wrong bit, would return a status value other than the one expected. Enable changes are injected mid-read and a second rd_go is pulsed while busy. A design that let commands through early, or restarted the handshake, would show a changed line level or an extra request edge. A silent supply drives the timeout path. A design that timed out late, raised a spurious status pulse or cleared the error on the next good read is caught there.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RELEASE = 2'd1,
    ST_AWAIT   = 2'd2,
    ST_RESTORE = 2'd3
  } pgr_state_e;

  function automatic int ms_to_cycles(input int ms, input int clk_per_ms);
    return ms * clk_per_ms;
  endfunction

endpackage

// File: rtl/pgr_sync.sv
module pgr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pgr_timer.sv
module pgr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = run && (cnt == limit - 1'b1);

endmodule

// File: rtl/pgr_capture.sv
module pgr_capture #(
  parameter int               N    = 3,
  parameter logic [N-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [N-1:0] lines,
  output logic [N-1:0] status,
  output logic         stat_vld
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (MASK[i]) begin : g_fitted
      always_ff @(posedge clk) begin
        if (rst) begin
          status[i] <= 1'b0;
        end else if (take) begin
          status[i] <= lines[i];
        end
      end
    end else begin : g_empty
      assign status[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_vld <= 1'b0;
    else     stat_vld <= take;
  end

endmodule

// File: rtl/pg_read_seq.sv
module pg_read_seq
  import pgr_pkg::*;
#(
  parameter int                 N_LINES     = 3,
  parameter int                 CLK_PER_MS  = 100000,
  parameter int                 RELEASE_MS  = 1,
  parameter int                 RESTORE_MS  = 2,
  parameter int                 TIMEOUT_MS  = 500,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [N_LINES-1:0] POP_MASK    = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] en_cmd,
  input  logic               rd_go,
  output logic [N_LINES-1:0] line_out,
  output logic [N_LINES-1:0] line_oe,
  input  logic [N_LINES-1:0] line_in,
  output logic               pg_req,
  input  logic               pg_valid,
  output logic [N_LINES-1:0] status,
  output logic               status_vld,
  output logic               busy,
  output logic               timeout_err
);

  localparam int REL_CYC  = ms_to_cycles(RELEASE_MS, CLK_PER_MS);
  localparam int REST_CYC = ms_to_cycles(RESTORE_MS, CLK_PER_MS);
  localparam int TO_CYC   = ms_to_cycles(TIMEOUT_MS, CLK_PER_MS);
  localparam int MAX_A    = (REL_CYC > REST_CYC) ? REL_CYC : REST_CYC;
  localparam int MAX_CYC  = (MAX_A > TO_CYC) ? MAX_A : TO_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  pgr_state_e st_q, st_d;
  logic [N_LINES:0] sync_in, sync_out;
  logic [N_LINES-1:0] lines_s;
  logic valid_s, hit, take, tclr;
  logic [CW-1:0] lim;

  assign sync_in = {pg_valid, line_in};

  pgr_sync #(.W(N_LINES + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(sync_in), .q(sync_out)
  );

  assign valid_s = sync_out[N_LINES];
  assign lines_s = sync_out[N_LINES-1:0];

  always_comb begin
    case (st_q)
      ST_RELEASE: lim = CW'(REL_CYC);
      ST_AWAIT:   lim = CW'(TO_CYC);
      default:    lim = CW'(REST_CYC);
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (rd_go) st_d = ST_RELEASE;
      ST_RELEASE: if (hit) st_d = ST_AWAIT;
      ST_AWAIT:   if (valid_s || hit) st_d = ST_RESTORE;
      ST_RESTORE: if (hit) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  assign tclr = (st_d != st_q);
  assign take = (st_q == ST_AWAIT) && valid_s;

  pgr_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .clear(tclr),
    .run(st_q != ST_IDLE), .limit(lim), .hit(hit)
  );

  pgr_capture #(.N(N_LINES), .MASK(POP_MASK)) u_cap (
    .clk(clk), .rst(rst), .take(take), .lines(lines_s),
    .status(status), .stat_vld(status_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      pg_req      <= 1'b0;
      line_oe     <= '1;
      line_out    <= '0;
      busy        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      st_q <= st_d;
      case (st_q)
        ST_IDLE: begin
          line_out <= en_cmd;
          if (rd_go) begin
            pg_req <= 1'b1;
            busy   <= 1'b1;
          end
        end
        ST_RELEASE: begin
          if (hit) line_oe <= '0;
        end
        ST_AWAIT: begin
          if (valid_s) begin
            pg_req <= 1'b0;
          end else if (hit) begin
            pg_req      <= 1'b0;
            timeout_err <= 1'b1;
          end
        end
        ST_RESTORE: begin
          if (hit) begin
            line_oe  <= '1;
            line_out <= en_cmd;
            busy     <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pgr_checker.sv
module pgr_checker #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         rd_go,
  input logic         pg_req,
  input logic [N-1:0] line_oe,
  input logic [N-1:0] line_out,
  input logic [N-1:0] status,
  input logic         status_vld,
  input logic         busy,
  input logic         timeout_err
);

  p_go_starts_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_go && !busy) |=> pg_req);

  p_release_under_req_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe[0]) |-> pg_req);

  p_capture_released_r5: assert property (@(posedge clk) disable iff (rst)
    status_vld |-> (line_oe == '0) && !pg_req);

  p_status_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !status_vld |-> $stable(status));

  p_redrive_after_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe[0]) |-> !pg_req && !busy);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $past(timeout_err) |-> timeout_err);

  p_req_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    pg_req |-> busy);

  p_lines_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(line_out));

endmodule

bind pg_read_seq pgr_checker #(.N(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .rd_go(rd_go), .pg_req(pg_req),
  .line_oe(line_oe), .line_out(line_out), .status(status),
  .status_vld(status_vld), .busy(busy), .timeout_err(timeout_err)
);

// File: tb/sim_pg_read_seq.sv
module sim_pg_read_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 3;
  localparam int CPM        = 10;
  localparam int REL_CYC    = 1 * CPM;
  localparam int REST_CYC   = 2 * CPM;
  localparam int TO_CYC     = 500 * CPM;
  localparam logic [N-1:0] MASK = 3'b011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] en_cmd = '0;
  logic rd_go = 1'b0;
  logic pg_valid = 1'b0;
  logic [N-1:0] sup_lines = '0;
  logic [N-1:0] line_in, line_out, line_oe, status;
  logic pg_req, status_vld, busy, timeout_err;

  assign line_in = (line_oe & line_out) | (~line_oe & sup_lines);

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_read_seq #(
    .N_LINES(N), .CLK_PER_MS(CPM), .RELEASE_MS(1), .RESTORE_MS(2),
    .TIMEOUT_MS(500), .SYNC_STAGES(2), .POP_MASK(MASK)
  ) u0 (
    .clk(clk), .rst(rst), .en_cmd(en_cmd), .rd_go(rd_go),
    .line_out(line_out), .line_oe(line_oe), .line_in(line_in),
    .pg_req(pg_req), .pg_valid(pg_valid), .status(status),
    .status_vld(status_vld), .busy(busy), .timeout_err(timeout_err)
  );

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] exp_q[$];
  int vld_pulses = 0, req_rises = 0;
  int rel_cnt = 0, rest_cnt = 0, wait_cnt = 0, last_wait = 0;
  bit rel_arm = 0, rest_arm = 0, wait_arm = 0;
  logic prev_req = 1'b0, prev_oe = 1'b1;
  bit sup_respond = 1;
  int sup_delay = 30;
  logic [N-1:0] sup_val = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // supply model
  initial begin
    forever begin
      @(posedge pg_req);
      if (sup_respond) begin
        wait (line_oe == '0);
        repeat (sup_delay) @(negedge clk);
        if (pg_req) begin
          sup_lines = sup_val;
          pg_valid  = 1'b1;
        end
      end
      wait (!pg_req);
      @(negedge clk);
      pg_valid = 1'b0;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      prev_req = 1'b0; prev_oe = 1'b1;
      rel_arm = 0; rest_arm = 0; wait_arm = 0;
    end else begin
      if (rel_arm)  rel_cnt++;
      if (rest_arm) rest_cnt++;
      if (wait_arm) wait_cnt++;
      if (pg_req && !prev_req) begin
        req_rises++; rel_arm = 1; rel_cnt = 0;
      end
      if (!line_oe[0] && prev_oe && rel_arm) begin
        chk(rel_cnt == REL_CYC, "R4", "release delay", rel_cnt, REL_CYC);
        rel_arm = 0; wait_arm = 1; wait_cnt = 0;
      end
      if (!pg_req && prev_req) begin
        rest_arm = 1; rest_cnt = 0;
        if (wait_arm) begin last_wait = wait_cnt; wait_arm = 0; end
      end
      if (line_oe[0] && !prev_oe && rest_arm) begin
        chk(rest_cnt == REST_CYC, "R6", "re-drive delay", rest_cnt, REST_CYC);
        rest_arm = 0;
      end
      if (busy != (pg_req | ~line_oe[0]))
        chk(0, "R8", "busy span", busy, pg_req | ~line_oe[0]);
      if (status_vld) begin
        vld_pulses++;
        if (exp_q.size() == 0) begin
          chk(0, "R5", "unexpected status pulse", status, 0);
        end else begin
          logic [N-1:0] e;
          e = exp_q.pop_front();
          chk(status == e, "R5", "masked status", status, e);
        end
      end
      prev_req = pg_req; prev_oe = line_oe[0];
    end
  end

  task automatic do_read(input logic [N-1:0] val, input bit respond);
    sup_val = val;
    sup_respond = respond;
    if (respond) exp_q.push_back(val & MASK);
    @(negedge clk) rd_go = 1'b1;
    @(negedge clk) rd_go = 1'b0;
    wait (!busy);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r0, v0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pg_req == 0 && busy == 0 && status_vld == 0, "R1", "reset ctrl",
        {pg_req, busy, status_vld}, 0);
    chk(line_oe == 3'b111, "R1", "reset oe", line_oe, 3'b111);
    chk(line_out == 0 && status == 0 && timeout_err == 0, "R1", "reset data",
        {line_out, status, timeout_err}, 0);
    rst = 1'b0;

    // R2 idle enable pass-through
    en_cmd = 3'b101;
    @(negedge clk);
    chk(line_out == 3'b101, "R2", "enable follow", line_out, 3'b101);
    en_cmd = 3'b110;
    @(negedge clk);
    chk(line_out == 3'b110, "R2", "enable follow 2", line_out, 3'b110);

    // R10 valid while idle ignored
    v0 = vld_pulses;
    sup_lines = 3'b111;
    pg_valid = 1'b1;
    repeat (6) @(negedge clk);
    pg_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(vld_pulses == v0 && status == 0 && pg_req == 0, "R10", "idle valid",
        {vld_pulses - v0, status, pg_req}, 0);

    // R5 read with mask
    do_read(3'b111, 1);
    chk(status == 3'b011, "R5", "status after read 1", status, 3'b011);
    chk(line_out == 3'b110 && line_oe == 3'b111, "R6", "restored lines",
        line_out, 3'b110);

    // R9 / R6 enable change mid-read
    fork
      do_read(3'b010, 1);
      begin
        wait (busy);
        repeat (15) @(negedge clk);
        en_cmd = 3'b001;
        repeat (3) @(negedge clk);
        chk(line_out == 3'b110, "R9", "held during read", line_out, 3'b110);
      end
    join
    chk(line_out == 3'b001, "R6", "held command applied", line_out, 3'b001);

    // masked-off line only
    do_read(3'b100, 1);
    chk(status == 3'b000, "R5", "empty position masked", status, 0);

    // R3 go while busy ignored
    r0 = req_rises;
    fork
      do_read(3'b101, 1);
      begin
        wait (busy);
        repeat (5) @(negedge clk);
        rd_go = 1'b1;
        @(negedge clk) rd_go = 1'b0;
      end
    join
    repeat (5) @(negedge clk);
    chk(req_rises == r0 + 1, "R3", "one request per read", req_rises - r0, 1);
    chk(busy == 0, "R3", "no restart", busy, 0);

    // R7 timeout
    v0 = vld_pulses;
    do_read(3'b111, 0);
    chk(timeout_err == 1, "R7", "timeout flag", timeout_err, 1);
    chk(last_wait == TO_CYC, "R7", "timeout length", last_wait, TO_CYC);
    chk(vld_pulses == v0, "R7", "no status pulse", vld_pulses - v0, 0);
    chk(status == 3'b001, "R7", "status kept", status, 3'b001);

    // R7 sticky across good read
    do_read(3'b011, 1);
    chk(status == 3'b011, "R5", "read after timeout", status, 3'b011);
    chk(timeout_err == 1, "R7", "flag sticky", timeout_err, 1);
    chk(exp_q.size() == 0, "R5", "all reads reported", exp_q.size(), 0);

    finish_run();
  end

endmodule